// File: doc/BRIEF.md
# Dual-Layer Color-Key Compositor

This block merges two image layers into one output frame, one pixel at a time. A base layer and an overlay layer each cover a rectangle of the output frame, set by inclusive top-left and bottom-right corners. Each layer also has a color-key range, given as a low bound and a high bound. For each output coordinate the block picks one of three sources: the overlay pixel, the base pixel or a fixed fill color.

The overlay wins wherever it covers the coordinate and its pixel is not keyed out. Where the overlay is absent or keyed, the base pixel is used, provided the base covers the coordinate and is not keyed itself. In every other case the fill color is output. These key decisions sit ahead of any later blending.

Coordinates and both candidate pixels arrive together on a valid/ready stream. The result leaves two register stages later on a second valid/ready stream. Back-pressure freezes the whole pipeline at once.

Top module: `dual_layer_keyer`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1.
- R2: When (x,y) lies inside the overlay rectangle and the overlay pixel is not keyed, `outPix` equals the overlay pixel and `outSrc` is 2.
- R3: When the overlay is keyed or does not cover (x,y), and the base covers (x,y) with an unkeyed pixel, `outPix` equals the base pixel and `outSrc` is 1.
- R4: When neither layer supplies an unkeyed covering pixel, `outPix` equals `bgColor` and `outSrc` is 0.
- R5: A coordinate is inside a rectangle when ulX ≤ x ≤ lrX and ulY ≤ y ≤ lrY, with all four corners included.
- R6: A pixel is keyed when each channel (red bits 23:16, green 15:8, blue 7:0) lies between the same channel of the low and high bounds, both bounds included. A single channel out of range means the pixel is not keyed.
- R7: A low bound of 0xFFFFFF with a high bound of 0x000000 keys no pixel, including 0xFFFFFF and 0x000000.
- R8: A pixel accepted at a rising edge, with `inReady` high at the next edge, appears with `outValid` high after that next edge (latency two cycles).
- R9: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and `outPix`, `outSrc` and `outValid` hold their values.
- R10: `outSrc` never takes the value 3 while `outValid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Block can take a beat |
| inX | input | 12 | Output-frame column of the beat |
| inY | input | 12 | Output-frame row of the beat |
| inPsPix | input | 24 | Base layer pixel at (x,y) |
| inAsPix | input | 24 | Overlay layer pixel at (x,y) |
| psUlX | input | 12 | Base rectangle left column |
| psUlY | input | 12 | Base rectangle top row |
| psLrX | input | 12 | Base rectangle right column |
| psLrY | input | 12 | Base rectangle bottom row |
| asUlX | input | 12 | Overlay rectangle left column |
| asUlY | input | 12 | Overlay rectangle top row |
| asLrX | input | 12 | Overlay rectangle right column |
| asLrY | input | 12 | Overlay rectangle bottom row |
| psKeyLo | input | 24 | Base key low bound |
| psKeyHi | input | 24 | Base key high bound |
| asKeyLo | input | 24 | Overlay key low bound |
| asKeyHi | input | 24 | Overlay key high bound |
| bgColor | input | 24 | Fill color |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Consumer takes the beat |
| outPix | output | 24 | Chosen pixel |
| outSrc | output | 2 | Source code: 0 fill, 1 base, 2 overlay |

## Verification
The hardest case to reach is an overlay pixel keyed out over a base pixel that is keyed out too. With random colors, landing inside both key ranges at once is very unlikely. The stimulus therefore draws each pixel from inside its layer's key range about half the time, and it places the two rectangles so that they overlap. Directed beats then place pixels exactly on the rectangle corners and on each channel's key bounds.

// File: rtl/dlk_pkg.sv
package dlk_pkg;
  typedef enum logic [1:0] {
    SRC_FILL    = 2'd0,
    SRC_BASE    = 2'd1,
    SRC_OVERLAY = 2'd2
  } src_e;

  typedef struct packed {
    logic load1;
    logic load2;
  } stage_strobe_t;
endpackage

// File: rtl/dlk_ctrl.sv
module dlk_ctrl
  import dlk_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inValid,
  output logic          inReady,
  output logic          outValid,
  input  logic          outReady,
  output stage_strobe_t strobe
);
  logic v1, v2;
  logic advance;

  assign advance  = !v2 || outReady;
  assign inReady  = advance;
  assign outValid = v2;
  assign strobe.load1 = advance && inValid;
  assign strobe.load2 = advance && v1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else if (advance) begin
      v1 <= inValid;
      v2 <= v1;
    end
  end
endmodule

// File: rtl/dlk_rect_hit.sv
module dlk_rect_hit #(
  parameter int COORD_W = 12
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [COORD_W-1:0] ulX,
  input  logic [COORD_W-1:0] ulY,
  input  logic [COORD_W-1:0] lrX,
  input  logic [COORD_W-1:0] lrY,
  output logic               hit
);
  assign hit = (x >= ulX) && (x <= lrX) && (y >= ulY) && (y <= lrY);
endmodule

// File: rtl/dlk_key_match.sv
module dlk_key_match #(
  parameter int CH_W  = 8,
  parameter int CH_N  = 3,
  parameter int PIX_W = CH_W * CH_N
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] lo,
  input  logic [PIX_W-1:0] hi,
  output logic             keyed
);
  logic [CH_N-1:0] chIn;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic [CH_W-1:0] p, l, h;
    assign p = pix[c*CH_W +: CH_W];
    assign l = lo[c*CH_W +: CH_W];
    assign h = hi[c*CH_W +: CH_W];
    assign chIn[c] = (p >= l) && (p <= h);
  end

  assign keyed = &chIn;
endmodule

// File: rtl/dlk_datapath.sv
module dlk_datapath
  import dlk_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CH_W    = 8,
  parameter int CH_N    = 3,
  parameter int PIX_W   = CH_W * CH_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  stage_strobe_t      strobe,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  logic [PIX_W-1:0]   inPsPix,
  input  logic [PIX_W-1:0]   inAsPix,
  input  logic [COORD_W-1:0] psUlX,
  input  logic [COORD_W-1:0] psUlY,
  input  logic [COORD_W-1:0] psLrX,
  input  logic [COORD_W-1:0] psLrY,
  input  logic [COORD_W-1:0] asUlX,
  input  logic [COORD_W-1:0] asUlY,
  input  logic [COORD_W-1:0] asLrX,
  input  logic [COORD_W-1:0] asLrY,
  input  logic [PIX_W-1:0]   psKeyLo,
  input  logic [PIX_W-1:0]   psKeyHi,
  input  logic [PIX_W-1:0]   asKeyLo,
  input  logic [PIX_W-1:0]   asKeyHi,
  input  logic [PIX_W-1:0]   bgColor,
  output logic [PIX_W-1:0]   outPix,
  output logic [1:0]         outSrc
);
  logic psInside, asInside, psKeyed, asKeyed;

  dlk_rect_hit #(.COORD_W(COORD_W)) u_psRect (
    .x(inX), .y(inY), .ulX(psUlX), .ulY(psUlY), .lrX(psLrX), .lrY(psLrY), .hit(psInside));
  dlk_rect_hit #(.COORD_W(COORD_W)) u_asRect (
    .x(inX), .y(inY), .ulX(asUlX), .ulY(asUlY), .lrX(asLrX), .lrY(asLrY), .hit(asInside));

  dlk_key_match #(.CH_W(CH_W), .CH_N(CH_N), .PIX_W(PIX_W)) u_psKey (
    .pix(inPsPix), .lo(psKeyLo), .hi(psKeyHi), .keyed(psKeyed));
  dlk_key_match #(.CH_W(CH_W), .CH_N(CH_N), .PIX_W(PIX_W)) u_asKey (
    .pix(inAsPix), .lo(asKeyLo), .hi(asKeyHi), .keyed(asKeyed));

  // stage 1: usable flags and pixel copies
  logic             s1PsUse, s1AsUse;
  logic [PIX_W-1:0] s1PsPix, s1AsPix;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1PsUse <= 1'b0;
      s1AsUse <= 1'b0;
      s1PsPix <= '0;
      s1AsPix <= '0;
    end else if (strobe.load1) begin
      s1PsUse <= psInside && !psKeyed;
      s1AsUse <= asInside && !asKeyed;
      s1PsPix <= inPsPix;
      s1AsPix <= inAsPix;
    end
  end

  // stage 2: priority choice overlay > base > fill
  src_e             selSrc;
  logic [PIX_W-1:0] selPix;

  always_comb begin
    if (s1AsUse) begin
      selSrc = SRC_OVERLAY;
      selPix = s1AsPix;
    end else if (s1PsUse) begin
      selSrc = SRC_BASE;
      selPix = s1PsPix;
    end else begin
      selSrc = SRC_FILL;
      selPix = bgColor;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outPix <= '0;
      outSrc <= SRC_FILL;
    end else if (strobe.load2) begin
      outPix <= selPix;
      outSrc <= selSrc;
    end
  end
endmodule

// File: rtl/dual_layer_keyer.sv
module dual_layer_keyer
  import dlk_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CH_W    = 8,
  parameter int CH_N    = 3,
  localparam int PIX_W  = CH_W * CH_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  output logic               inReady,
  input  logic [COORD_W-1:0] inX,
  input  logic [COORD_W-1:0] inY,
  input  logic [PIX_W-1:0]   inPsPix,
  input  logic [PIX_W-1:0]   inAsPix,
  input  logic [COORD_W-1:0] psUlX,
  input  logic [COORD_W-1:0] psUlY,
  input  logic [COORD_W-1:0] psLrX,
  input  logic [COORD_W-1:0] psLrY,
  input  logic [COORD_W-1:0] asUlX,
  input  logic [COORD_W-1:0] asUlY,
  input  logic [COORD_W-1:0] asLrX,
  input  logic [COORD_W-1:0] asLrY,
  input  logic [PIX_W-1:0]   psKeyLo,
  input  logic [PIX_W-1:0]   psKeyHi,
  input  logic [PIX_W-1:0]   asKeyLo,
  input  logic [PIX_W-1:0]   asKeyHi,
  input  logic [PIX_W-1:0]   bgColor,
  output logic               outValid,
  input  logic               outReady,
  output logic [PIX_W-1:0]   outPix,
  output logic [1:0]         outSrc
);
  stage_strobe_t strobe;

  dlk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .strobe(strobe));

  dlk_datapath #(.COORD_W(COORD_W), .CH_W(CH_W), .CH_N(CH_N), .PIX_W(PIX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .inX(inX), .inY(inY),
    .inPsPix(inPsPix), .inAsPix(inAsPix),
    .psUlX(psUlX), .psUlY(psUlY), .psLrX(psLrX), .psLrY(psLrY),
    .asUlX(asUlX), .asUlY(asUlY), .asLrX(asLrX), .asLrY(asLrY),
    .psKeyLo(psKeyLo), .psKeyHi(psKeyHi), .asKeyLo(asKeyLo), .asKeyHi(asKeyHi),
    .bgColor(bgColor), .outPix(outPix), .outSrc(outSrc));
endmodule

// File: rtl/dual_layer_keyer_chk.sv
module dual_layer_keyer_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outPix,
  input logic [1:0]       outSrc
);
  // R9: stalled output holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid && $stable(outPix) && $stable(outSrc));

  // R9: no intake while the output is stalled
  a_r9_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |-> !inReady);

  // R8: two-cycle latency
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(inValid && inReady, 2) && $past(inReady) |-> outValid);

  // R10: legal source code
  a_r10_src_legal: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> outSrc != 2'd3);
endmodule

bind dual_layer_keyer dual_layer_keyer_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outPix(outPix), .outSrc(outSrc));

// File: tb/dual_layer_keyer_test.sv
module dual_layer_keyer_test;
  localparam int CW = 12;
  localparam int PW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [CW-1:0] inX = '0, inY = '0;
  logic [PW-1:0] inPsPix = '0, inAsPix = '0;
  logic [CW-1:0] psUlX = '0, psUlY = '0, psLrX = '0, psLrY = '0;
  logic [CW-1:0] asUlX = '0, asUlY = '0, asLrX = '0, asLrY = '0;
  logic [PW-1:0] psKeyLo = 24'hFFFFFF, psKeyHi = '0, asKeyLo = 24'hFFFFFF, asKeyHi = '0;
  logic [PW-1:0] bgColor = 24'h123456;
  logic outValid;
  logic outReady = 1'b0;
  logic [PW-1:0] outPix;
  logic [1:0] outSrc;

  int compared = 0;
  int mismatched = 0;
  logic [PW+1:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  dual_layer_keyer uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
    .inX(inX), .inY(inY), .inPsPix(inPsPix), .inAsPix(inAsPix),
    .psUlX(psUlX), .psUlY(psUlY), .psLrX(psLrX), .psLrY(psLrY),
    .asUlX(asUlX), .asUlY(asUlY), .asLrX(asLrX), .asLrY(asLrY),
    .psKeyLo(psKeyLo), .psKeyHi(psKeyHi), .asKeyLo(asKeyLo), .asKeyHi(asKeyHi),
    .bgColor(bgColor), .outValid(outValid), .outReady(outReady),
    .outPix(outPix), .outSrc(outSrc));

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic inRect(logic [CW-1:0] x, y, ux, uy, lx, ly);
    return x >= ux && x <= lx && y >= uy && y <= ly;
  endfunction

  function automatic logic keyed(logic [PW-1:0] p, lo, hi);
    for (int c = 0; c < 3; c++)
      if (p[c*8 +: 8] < lo[c*8 +: 8] || p[c*8 +: 8] > hi[c*8 +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  // {src, pix}: overlay=2, base=1, fill=0
  function automatic logic [PW+1:0] model(logic [CW-1:0] x, y, logic [PW-1:0] ps, as);
    if (inRect(x, y, asUlX, asUlY, asLrX, asLrY) && !keyed(as, asKeyLo, asKeyHi)) return {2'd2, as};
    if (inRect(x, y, psUlX, psUlY, psLrX, psLrY) && !keyed(ps, psKeyLo, psKeyHi)) return {2'd1, ps};
    return {2'd0, bgColor};
  endfunction

  function automatic string srcTag(logic [1:0] s);
    return s == 2'd2 ? "R2" : (s == 2'd1 ? "R3" : "R4");
  endfunction

  task automatic popCheck();
    logic [PW+1:0] e;
    string t;
    if (expQ.size() == 0) begin
      check(1'b0, "R8 unexpected output", {6'd0, outSrc, outPix}, 32'd0);
      return;
    end
    e = expQ.pop_front();
    t = tagQ.pop_front();
    check({outSrc, outPix} == e && outSrc != 2'd3, t, {6'd0, outSrc, outPix}, {6'd0, e});
  endtask

  task automatic cycle(input logic vin, input logic [CW-1:0] x, y, input logic [PW-1:0] ps, as,
                       input string tag, input logic rdy);
    logic [PW+1:0] e;
    @(negedge clk);
    inValid = vin; inX = x; inY = y; inPsPix = ps; inAsPix = as; outReady = rdy;
    #1;
    if (inValid && inReady) begin
      e = model(x, y, ps, as);
      expQ.push_back(e);
      tagQ.push_back(tag == "" ? srcTag(e[PW+1:PW]) : tag);
    end
    if (outValid && outReady) popCheck();
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) cycle(1'b0, '0, '0, '0, '0, "", 1'b1);
  endtask

  function automatic logic [PW-1:0] pickPix(logic [PW-1:0] lo, hi);
    logic [PW-1:0] p;
    if ($urandom % 2 == 0) return PW'($urandom);
    for (int c = 0; c < 3; c++)
      p[c*8 +: 8] = lo[c*8 +: 8] + 8'($urandom % (int'(hi[c*8 +: 8]) - int'(lo[c*8 +: 8]) + 1));
    return p;
  endfunction

  function automatic logic [PW-1:0] randLo();
    logic [PW-1:0] v;
    for (int c = 0; c < 3; c++) v[c*8 +: 8] = 8'($urandom % 200);
    return v;
  endfunction

  function automatic logic [PW-1:0] randHi(logic [PW-1:0] lo);
    logic [PW-1:0] v;
    for (int c = 0; c < 3; c++) v[c*8 +: 8] = lo[c*8 +: 8] + 8'($urandom % 56);
    return v;
  endfunction

  initial begin : watchdog
    #(20 * 150000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    logic [PW-1:0] held;
    logic [1:0] heldSrc;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", {31'd0, outValid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", {31'd0, outValid}, 32'd0);
    check(inReady == 1'b1, "R1 inReady after reset", {31'd0, inReady}, 32'd1);

    // Rectangles for directed work; keys disabled (R7)
    psUlX = 10; psUlY = 20; psLrX = 30; psLrY = 40;
    asUlX = 12; asUlY = 22; asLrX = 28; asLrY = 38;

    // R8: latency of two cycles
    @(negedge clk);
    outReady = 1'b1; inValid = 1'b1; inX = 15; inY = 25; inPsPix = 24'h111111; inAsPix = 24'h222222;
    expQ.push_back(model(15, 25, 24'h111111, 24'h222222)); tagQ.push_back("R8 data");
    @(negedge clk);
    inValid = 1'b0;
    #1 check(outValid == 1'b0, "R8 not early", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    #1 check(outValid == 1'b1, "R8 valid after two edges", {31'd0, outValid}, 32'd1);
    popCheck();
    drain();

    // R5: corners inclusive
    cycle(1'b1, 10, 20, 24'hA0A0A0, 24'hB0B0B0, "R5 base UL corner", 1'b1);
    cycle(1'b1, 30, 40, 24'hA1A1A1, 24'hB1B1B1, "R5 base LR corner", 1'b1);
    cycle(1'b1, 9, 20, 24'hA2A2A2, 24'hB2B2B2, "R5 left of base", 1'b1);
    cycle(1'b1, 31, 40, 24'hA3A3A3, 24'hB3B3B3, "R5 right of base", 1'b1);
    cycle(1'b1, 30, 41, 24'hA4A4A4, 24'hB4B4B4, "R5 below base", 1'b1);
    cycle(1'b1, 12, 22, 24'hA5A5A5, 24'hB5B5B5, "R5 overlay UL corner", 1'b1);
    cycle(1'b1, 28, 38, 24'hA6A6A6, 24'hB6B6B6, "R5 overlay LR corner", 1'b1);
    cycle(1'b1, 29, 38, 24'hA7A7A7, 24'hB7B7B7, "R5 right of overlay", 1'b1);
    // R7: disabled keys never match extremes
    cycle(1'b1, 20, 30, 24'h000000, 24'hFFFFFF, "R7 overlay white", 1'b1);
    cycle(1'b1, 20, 30, 24'hFFFFFF, 24'h000000, "R7 overlay black", 1'b1);
    cycle(1'b1, 11, 21, 24'hFFFFFF, 24'h000000, "R7 base white", 1'b1);
    drain();

    // R6: per-channel inclusive bounds
    asKeyLo = 24'h0A141E; asKeyHi = 24'h323C46;
    psKeyLo = 24'h102030; psKeyHi = 24'h405060;
    cycle(1'b1, 20, 30, 24'h777777, 24'h0A141E, "R6 overlay at low bounds", 1'b1);
    cycle(1'b1, 20, 30, 24'h777777, 24'h323C46, "R6 overlay at high bounds", 1'b1);
    cycle(1'b1, 20, 30, 24'h777777, 24'h333C46, "R6 red above high", 1'b1);
    cycle(1'b1, 20, 30, 24'h777777, 24'h0A131E, "R6 green below low", 1'b1);
    cycle(1'b1, 20, 30, 24'h777777, 24'h0A1447, "R6 blue above high", 1'b1);
    cycle(1'b1, 20, 30, 24'h102030, 24'h202020, "R4 both keyed", 1'b1);
    cycle(1'b1, 11, 21, 24'h405060, 24'h202020, "R4 base keyed, no overlay", 1'b1);
    cycle(1'b1, 5, 5, 24'h777777, 24'h777777, "R4 outside both", 1'b1);
    drain();

    // R9: stall holds output
    for (int i = 0; i < 3; i++) cycle(1'b1, 20, 30, 24'h555555, 24'h00AA00 + PW'(i), "R9 stalled data", 1'b0);
    #1 held = outPix; heldSrc = outSrc;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      #1;
      check(outValid == 1'b1, "R9 valid held", {31'd0, outValid}, 32'd1);
      check(outPix == held && outSrc == heldSrc, "R9 data held", {8'd0, outPix}, {8'd0, held});
      check(inReady == 1'b0, "R9 no intake", {31'd0, inReady}, 32'd0);
    end
    drain();

    // Random phases
    for (int ph = 0; ph < 30; ph++) begin
      psUlX = CW'($urandom % 40); psLrX = psUlX + CW'($urandom % 40);
      psUlY = CW'($urandom % 40); psLrY = psUlY + CW'($urandom % 40);
      asUlX = CW'($urandom % 40); asLrX = asUlX + CW'($urandom % 40);
      asUlY = CW'($urandom % 40); asLrY = asUlY + CW'($urandom % 40);
      psKeyLo = randLo(); psKeyHi = randHi(psKeyLo);
      asKeyLo = randLo(); asKeyHi = randHi(asKeyLo);
      if (ph % 7 == 3) begin psKeyLo = 24'hFFFFFF; psKeyHi = 24'h0; end
      if (ph % 5 == 2) begin asKeyLo = 24'hFFFFFF; asKeyHi = 24'h0; end
      bgColor = PW'($urandom);
      for (int n = 0; n < 300; n++)
        cycle($urandom % 4 != 0, CW'($urandom % 80), CW'($urandom % 80),
              pickPix(psKeyLo, psKeyHi), pickPix(asKeyLo, asKeyHi), "", $urandom % 3 != 0);
      drain();
    end

    check(expQ.size() == 0, "R8 all beats delivered", expQ.size(), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule